// File: doc/BRIEF.md
# Interleaved Four-Thread Fetch Sequencer

This block chooses the hardware thread that fetches next and supplies the instruction address for that fetch. It serves an in-order, single-issue, five-stage pipeline that four hardware threads share. It keeps one program counter per thread. It steps through the threads in a fixed circular order, one thread per clock, so each thread gets exactly one fetch slot in every window of four cycles.

The pipeline sends each thread's next program counter back early, before writeback. The fetch that thread makes four cycles later therefore already uses the right address. The pipeline needs no stall, no prediction and no speculative fetch.

A thread whose instruction is still waiting on slow memory stays in the rotation. Its slot fetches the same address again and marks the fetch as a replay. An exception-style redirect loads a new address for one thread only. Each update input carries a thread index, so updates for different threads can land in the same cycle without affecting one another.

Top module: `rr_fetch_sequencer`

## Requirements
- R1: While reset is asserted, `fetch_valid` is 0. The first valid fetch after reset is for thread 0. Each thread t starts at address `START_BASE + t*START_STRIDE`, with the replay flag clear.
- R2: Once valid, `fetch_tid` steps 0,1,2,3,0,… by one thread every cycle. No thread is skipped or repeated, whatever the replay, redirect or commit traffic.
- R3: A commit (`commit_valid`, thread `commit_tid`, address `commit_pc`) makes that thread's next fetch present `commit_pc` with `fetch_replay` low.
- R4: A replay request for a thread makes that thread's next fetch present the same address as before, with `fetch_replay` high. The replay state persists over later slots until a commit or a redirect for that thread.
- R5: A redirect (`redirect_valid`, `redirect_tid`, `redirect_pc`) makes that thread's next fetch present `redirect_pc` with `fetch_replay` low. The addresses and replay flags of the other threads are unchanged.
- R6: When several update inputs name the same thread in one cycle, the redirect wins over the replay, and the replay wins over the commit. A commit that loses to a replay is discarded.
- R7: Updates that name different threads in the same cycle all take effect, each on its own thread.
- R8: A thread that receives no update presents the same address and replay flag at its next fetch.
- R9: An update is seen at the first fetch of that thread that follows the clock edge at which the update is sampled. If that thread is fetching in the cycle the update is sampled, that fetch still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | Next-PC commit strobe |
| commit_tid | input | TID_W | Thread that the commit targets |
| commit_pc | input | PC_W | Committed next address |
| replay_valid | input | 1 | Replay request strobe |
| replay_tid | input | TID_W | Thread whose instruction must be replayed |
| redirect_valid | input | 1 | Exception redirect strobe |
| redirect_tid | input | TID_W | Thread that the redirect targets |
| redirect_pc | input | PC_W | Redirect target address |
| fetch_valid | output | 1 | The fetch in this cycle is valid |
| fetch_tid | output | TID_W | Thread fetching in this cycle |
| fetch_pc | output | PC_W | Fetch address for that thread |
| fetch_replay | output | 1 | This fetch re-issues a waiting instruction |

## Verification
The bench runs the rotation under long stretches of traffic and checks every cycle. A design that skipped or stalled a waiting thread would break the 0,1,2,3 order. A design that advanced the address on a replay would fetch past the unfinished instruction. The bench drives all three update kinds at one thread in the same cycle, in every combination. A wrong priority would let a late commit overwrite a redirect, or drop a replay. It also sends updates for several threads at once, and sends updates to a thread in its own fetch cycle. These catch an update that leaks into a neighbour's slot, and timing that is off by one slot.

// File: rtl/rr_fetch_sequencer.sv
module rr_fetch_sequencer #(
  parameter int unsigned NTHREADS = 4,
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] START_BASE = 32'h0000_1000,
  parameter logic [PC_W-1:0] START_STRIDE = 32'h0000_0400,
  localparam int unsigned TID_W = $clog2(NTHREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_valid,
  input  logic [TID_W-1:0] commit_tid,
  input  logic [PC_W-1:0]  commit_pc,
  input  logic             replay_valid,
  input  logic [TID_W-1:0] replay_tid,
  input  logic             redirect_valid,
  input  logic [TID_W-1:0] redirect_tid,
  input  logic [PC_W-1:0]  redirect_pc,
  output logic             fetch_valid,
  output logic [TID_W-1:0] fetch_tid,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_replay
);

  localparam logic [TID_W-1:0] LAST = TID_W'(NTHREADS - 1);

  logic [PC_W-1:0]     pc_q [NTHREADS];
  logic [NTHREADS-1:0] rep_q;
  logic [TID_W-1:0]    slot_q;
  logic                valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      valid_q <= 1'b1;
      if (valid_q) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    wire hit_dir = redirect_valid && (redirect_tid == TID_W'(t));
    wire hit_rep = replay_valid   && (replay_tid   == TID_W'(t));
    wire hit_com = commit_valid   && (commit_tid   == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[t]  <= START_BASE + START_STRIDE * PC_W'(t);
        rep_q[t] <= 1'b0;
      end else if (hit_dir) begin
        pc_q[t]  <= redirect_pc;
        rep_q[t] <= 1'b0;
      end else if (hit_rep) begin
        rep_q[t] <= 1'b1;
      end else if (hit_com) begin
        pc_q[t]  <= commit_pc;
        rep_q[t] <= 1'b0;
      end
    end
  end

  assign fetch_valid  = valid_q;
  assign fetch_tid    = slot_q;
  assign fetch_pc     = pc_q[slot_q];
  assign fetch_replay = rep_q[slot_q];

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> !fetch_valid); // R1

  AST_STEADY_ROTATION: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && $past(fetch_valid) |->
      fetch_tid == (($past(fetch_tid) == LAST) ? '0 : $past(fetch_tid) + 1'b1)); // R2

  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !(replay_valid && replay_tid == commit_tid)
      && !(redirect_valid && redirect_tid == commit_tid) |=>
      pc_q[$past(commit_tid)] == $past(commit_pc) && !rep_q[$past(commit_tid)]); // R3

  AST_REPLAY_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid && !(redirect_valid && redirect_tid == replay_tid) |=>
      rep_q[$past(replay_tid)] && pc_q[$past(replay_tid)] == $past(pc_q[replay_tid])); // R4

  AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=>
      pc_q[$past(redirect_tid)] == $past(redirect_pc) && !rep_q[$past(redirect_tid)]); // R6

endmodule

// File: tb/rr_fetch_sequencer_test.sv
module rr_fetch_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_valid = 1'b0, replay_valid = 1'b0, redirect_valid = 1'b0;
  logic [1:0]  commit_tid = '0, replay_tid = '0, redirect_tid = '0;
  logic [31:0] commit_pc = '0, redirect_pc = '0;
  logic        fetch_valid, fetch_replay;
  logic [1:0]  fetch_tid;
  logic [31:0] fetch_pc;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  logic [31:0] exp_pc [NT];
  logic        exp_rep [NT];
  int          exp_slot = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_fetch_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .commit_valid(commit_valid), .commit_tid(commit_tid), .commit_pc(commit_pc),
    .replay_valid(replay_valid), .replay_tid(replay_tid),
    .redirect_valid(redirect_valid), .redirect_tid(redirect_tid), .redirect_pc(redirect_pc),
    .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
    .fetch_replay(fetch_replay)
  );

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit cv, input int ct, input logic [31:0] cp,
                      input bit pv, input int pt,
                      input bit dv, input int dt, input logic [31:0] dp);
    chk("R2 valid", {31'd0, fetch_valid}, 32'd1);
    chk("R2 tid", {30'd0, fetch_tid}, exp_slot);
    chk({tag, " pc"}, fetch_pc, exp_pc[exp_slot]);
    chk({tag, " replay"}, {31'd0, fetch_replay}, {31'd0, exp_rep[exp_slot]});
    commit_valid = cv;   commit_tid = 2'(ct);   commit_pc = cp;
    replay_valid = pv;   replay_tid = 2'(pt);
    redirect_valid = dv; redirect_tid = 2'(dt); redirect_pc = dp;
    for (int t = 0; t < NT; t++) begin
      if (dv && dt == t) begin exp_pc[t] = dp; exp_rep[t] = 1'b0; end
      else if (pv && pt == t) exp_rep[t] = 1'b1;
      else if (cv && ct == t) begin exp_pc[t] = cp; exp_rep[t] = 1'b0; end
    end
    exp_slot = (exp_slot + 1) % NT;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      exp_pc[t] = 32'h1000 + 32'h400 * t;
      exp_rep[t] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, fetch_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: start addresses, thread 0 first
    tag = "R1";
    repeat (4) idle();

    // R3: commits to random threads, including the thread fetching now (R9)
    tag = "R3";
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r = rnd();
      step(1, r[1:0], {r[31:8], 8'h00} | 32'h4, 0, 0, 0, 0, 0);
    end

    // R4: replay persists across slots until a commit
    tag = "R4";
    step(0, 0, 0, 1, 2, 0, 0, 0);
    repeat (9) idle();
    step(1, 2, 32'h0000_2F00, 0, 0, 0, 0, 0);
    repeat (4) idle();
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r = rnd();
      step(r[8], r[3:2], {r[31:10], 10'h0}, r[9], r[1:0], 0, 0, 0);
    end

    // R5: redirect one thread while others are mid-replay
    tag = "R5";
    step(0, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 32'h0000_0018);
    repeat (8) idle();

    // R6: all three strobes aimed at one thread, every subset
    tag = "R6";
    for (int s = 0; s < 32; s++) begin
      logic [31:0] r = rnd();
      step(s[0], s[4:3], 32'hC000_0000 | (r & 32'hFFF0),
           s[1], s[4:3], s[2], s[4:3], 32'hE000_0000 | (r & 32'h0FF0));
    end

    // R7: mixed traffic, different threads in the same cycle
    tag = "R7";
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r = rnd();
      step(r[0], r[3:2], {r[31:12], 12'h0}, r[1], r[5:4],
           r[6] & r[7], r[9:8], {r[23:12], 20'h00040});
    end

    // R8: no updates, every thread holds
    tag = "R8";
    repeat (12) idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule